// File: doc/BRIEF.md
# Custom Instruction Unit with Miss Trap

This block is a stateless functional unit placed next to a processor's register file, alongside the ordinary execution units. The processor issues a custom instruction to it. The instruction carries an 11-bit function identifier and two register operands. The unit compares the identifier with the identifier of the function currently resident.

- If the two match, the unit computes the result combinationally and presents it in the same cycle, with a write-back strobe.
- If they do not match, the unit raises a miss trap instead. Software can then load the wanted function and retry.

A configuration port makes a function resident. It writes the resident identifier, a 2-bit operation select and a merge mask, and they take effect from the next clock edge. The resident function is picked from four built-in combinational operations:

| Select | Operation |
|---|---|
| 0 | population count |
| 1 | bit reverse |
| 2 | masked merge |
| 3 | unsigned saturating add |

No operand data is kept between instructions. A context switch therefore needs nothing saved or restored beyond the configuration, which the trap path rebuilds on demand.

Top module: `cfu_unit`

## Requirements
- R1: After reset no function is resident: any issued instruction, whatever its identifier (including 0), raises `trap` and leaves `res_valid` low.
- R2: When `iss_valid` is high and `iss_id` equals the resident identifier, `res_valid` is high, `trap` is low and `res_data` holds the result in that same cycle.
- R3: When `iss_valid` is high and `iss_id` differs from the resident identifier (or nothing is resident), `trap` is high, `res_valid` is low and `res_data` is zero.
- R4: With `iss_valid` low, both `trap` and `res_valid` are low and `res_data` is zero.
- R5: A configuration write (`cfg_we` high at a rising edge) takes effect from the following cycle. During the cycle of the write, the previous configuration still decides match and result.
- R6: Select 0 returns the number of set bits in `iss_a`, zero-extended.
- R7: Select 1 returns `iss_a` with bit i moved to bit W-1-i.
- R8: Select 2 returns `(iss_a & mask) | (iss_b & ~mask)`, where the mask is the one loaded with the configuration.
- R9: Select 3 returns the unsigned sum `iss_a + iss_b`, clamped to all ones when it overflows W bits.
- R10: Results are stateless: the same operands and configuration always give the same result, whatever instructions came before.
- R11: `trap` and `res_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_id | input | 11 | Identifier to make resident |
| cfg_sel | input | 2 | Operation select (0 popcount, 1 reverse, 2 merge, 3 saturating add) |
| cfg_mask | input | 32 | Merge mask loaded with the configuration |
| iss_valid | input | 1 | Custom instruction issued this cycle |
| iss_id | input | 11 | Function identifier of the issued instruction |
| iss_a | input | 32 | First source operand |
| iss_b | input | 32 | Second source operand |
| res_valid | output | 1 | Result valid and register write-back enable |
| res_data | output | 32 | Result value |
| trap | output | 1 | Function miss trap |

## Verification
Several properties are checked by the assertions on every cycle:
- the exclusion between trap and write-back;
- the quiet outputs when nothing is issued;
- the zeroed data on a trap;
- the absence of results while nothing is resident;
- the loading of the configuration at the edge after a write;
- the clamping of the saturating add.

Other behaviour can only be shown by the bench's scenarios:
- the exact values of each operation;
- the one-cycle lag of a new configuration against an instruction issued in the write cycle;
- the repeatability of results after unrelated traffic.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int unsigned ID_W  = 11;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    FN_POPCNT = 2'd0,
    FN_BITREV = 2'd1,
    FN_MERGE  = 2'd2,
    FN_SATADD = 2'd3
  } fn_sel_e;
endpackage

// File: rtl/cfu_cfg_reg.sv
module cfu_cfg_reg
  import cfu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [ID_W-1:0] cfg_id,
  input  fn_sel_e         cfg_sel,
  input  logic [W-1:0]    cfg_mask,
  output logic            cur_vld,
  output logic [ID_W-1:0] cur_id,
  output fn_sel_e         cur_sel,
  output logic [W-1:0]    cur_mask
);
  logic            vld_d;
  logic [ID_W-1:0] id_d;
  fn_sel_e         sel_d;
  logic [W-1:0]    mask_d;

  // next-state: load the whole configuration as one unit
  always_comb begin
    vld_d  = cur_vld;
    id_d   = cur_id;
    sel_d  = cur_sel;
    mask_d = cur_mask;
    if (cfg_we) begin
      vld_d  = 1'b1;
      id_d   = cfg_id;
      sel_d  = cfg_sel;
      mask_d = cfg_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_vld  <= 1'b0;
      cur_id   <= '0;
      cur_sel  <= FN_POPCNT;
      cur_mask <= '0;
    end else begin
      cur_vld  <= vld_d;
      cur_id   <= id_d;
      cur_sel  <= sel_d;
      cur_mask <= mask_d;
    end
  end

  // R5: a write becomes resident at the next edge
  a_r5_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cur_vld && cur_id == $past(cfg_id) && cur_sel == $past(cfg_sel)
                && cur_mask == $past(cfg_mask)));

  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(cur_id) && $stable(cur_sel) && $stable(cur_mask)));
endmodule

// File: rtl/cfu_match.sv
module cfu_match
  import cfu_pkg::*;
(
  input  logic            iss_valid,
  input  logic [ID_W-1:0] iss_id,
  input  logic            cur_vld,
  input  logic [ID_W-1:0] cur_id,
  output logic            hit,
  output logic            miss
);
  logic id_eq;

  always_comb begin
    id_eq = (iss_id == cur_id);
    hit   = iss_valid &&  (cur_vld && id_eq);
    miss  = iss_valid && !(cur_vld && id_eq);
  end
endmodule

// File: rtl/cfu_ops.sv
module cfu_ops
  import cfu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  fn_sel_e      sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] mask,
  output logic [W-1:0] y
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] pop;
  logic [W-1:0]     rev;
  logic [W-1:0]     merged;
  logic [W:0]       sum_ext;
  logic [W-1:0]     sat;

  // population count
  always_comb begin
    pop = '0;
    for (int i = 0; i < W; i++) begin
      pop = pop + CNT_W'(a[i]);
    end
  end

  // bit reverse as pure wiring
  for (genvar g = 0; g < W; g++) begin : g_rev
    assign rev[g] = a[W-1-g];
  end

  // merge and saturating add
  always_comb begin
    merged  = (a & mask) | (b & ~mask);
    sum_ext = {1'b0, a} + {1'b0, b};
    sat     = sum_ext[W] ? {W{1'b1}} : sum_ext[W-1:0];
  end

  always_comb begin
    unique case (sel)
      FN_POPCNT: y = W'(pop);
      FN_BITREV: y = rev;
      FN_MERGE:  y = merged;
      FN_SATADD: y = sat;
      default:   y = '0;
    endcase
  end

  // R9: a clamped sum never falls below either operand
  always_comb begin
    if (sel == FN_SATADD) begin
      a_r9_sat_floor: assert (y >= a && y >= b);
    end
  end

  // R6: a bit count cannot exceed the width
  always_comb begin
    if (sel == FN_POPCNT) begin
      a_r6_pop_range: assert (y <= W);
    end
  end
endmodule

// File: rtl/cfu_unit.sv
module cfu_unit
  import cfu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [ID_W-1:0]  cfg_id,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [W-1:0]     cfg_mask,
  input  logic             iss_valid,
  input  logic [ID_W-1:0]  iss_id,
  input  logic [W-1:0]     iss_a,
  input  logic [W-1:0]     iss_b,
  output logic             res_valid,
  output logic [W-1:0]     res_data,
  output logic             trap
);
  logic            cur_vld;
  logic [ID_W-1:0] cur_id;
  fn_sel_e         cur_sel;
  logic [W-1:0]    cur_mask;
  logic            hit;
  logic            miss;
  logic [W-1:0]    op_y;

  cfu_cfg_reg #(.W(W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_id   (cfg_id),
    .cfg_sel  (fn_sel_e'(cfg_sel)),
    .cfg_mask (cfg_mask),
    .cur_vld  (cur_vld),
    .cur_id   (cur_id),
    .cur_sel  (cur_sel),
    .cur_mask (cur_mask)
  );

  cfu_match u_match (
    .iss_valid (iss_valid),
    .iss_id    (iss_id),
    .cur_vld   (cur_vld),
    .cur_id    (cur_id),
    .hit       (hit),
    .miss      (miss)
  );

  cfu_ops #(.W(W)) u_ops (
    .sel  (cur_sel),
    .a    (iss_a),
    .b    (iss_b),
    .mask (cur_mask),
    .y    (op_y)
  );

  always_comb begin
    res_valid = hit;
    trap      = miss;
    res_data  = hit ? op_y : '0;
  end

  // R11: write-back and trap exclude each other
  a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && trap));

  // R4: quiet when nothing is issued
  a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> (!res_valid && !trap && res_data == '0));

  // R3: a trap carries no data
  a_r3_trap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (res_data == '0 && iss_valid));

  // R1: nothing resident means no write-back
  a_r1_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_vld |-> !res_valid);

  // R2: a write-back only for an issued instruction naming the resident id
  a_r2_hit_id: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (iss_valid && iss_id == cur_id));
endmodule

// File: tb/cfu_unit_tb.sv
module cfu_unit_tb;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [10:0]   cfg_id;
  logic [1:0]    cfg_sel;
  logic [W-1:0]  cfg_mask;
  logic          iss_valid;
  logic [10:0]   iss_id;
  logic [W-1:0]  iss_a;
  logic [W-1:0]  iss_b;
  logic          res_valid;
  logic [W-1:0]  res_data;
  logic          trap;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // bench model of the resident configuration
  bit           m_vld  = 1'b0;
  logic [10:0]  m_id   = '0;
  logic [1:0]   m_sel  = '0;
  logic [W-1:0] m_mask = '0;

  always #2.5 clk = ~clk;

  cfu_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_sel(cfg_sel), .cfg_mask(cfg_mask),
    .iss_valid(iss_valid), .iss_id(iss_id), .iss_a(iss_a), .iss_b(iss_b),
    .res_valid(res_valid), .res_data(res_data), .trap(trap)
  );

  function automatic logic [W-1:0] f_pop(logic [W-1:0] a);
    logic [W-1:0] c = '0;
    for (int i = 0; i < W; i++) c += W'(a[i]);
    return c;
  endfunction

  function automatic logic [W-1:0] f_rev(logic [W-1:0] a);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = a[W-1-i];
    return r;
  endfunction

  function automatic logic [W-1:0] f_sat(logic [W-1:0] a, logic [W-1:0] b);
    longint unsigned s = longint'(a) + longint'(b);
    if (s > 64'hFFFF_FFFF) return '1;
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] f_exp(logic [1:0] sel, logic [W-1:0] a,
                                         logic [W-1:0] b, logic [W-1:0] m);
    case (sel)
      2'd0:    return f_pop(a);
      2'd1:    return f_rev(a);
      2'd2:    return (a & m) | (b & ~m);
      default: return f_sat(a, b);
    endcase
  endfunction

  task automatic check(string req, logic ev, logic et, logic [W-1:0] ed);
    n_chk++;
    if (res_valid !== ev || trap !== et || res_data !== ed) begin
      n_err++;
      $display("FAIL %s: actual valid=%0b trap=%0b data=%h expected valid=%0b trap=%0b data=%h",
               req, res_valid, trap, res_data, ev, et, ed);
    end
  endtask

  // drive an issue at the falling edge, check shortly after against the model
  task automatic issue_chk(string req, logic [10:0] id, logic [W-1:0] a, logic [W-1:0] b);
    bit h;
    @(negedge clk);
    iss_valid = 1'b1; iss_id = id; iss_a = a; iss_b = b;
    #1;
    h = m_vld && (id == m_id);
    check(req, h, !h, h ? f_exp(m_sel, a, b, m_mask) : '0);
  endtask

  task automatic load_cfg(logic [10:0] id, logic [1:0] sel, logic [W-1:0] m);
    @(negedge clk);
    iss_valid = 1'b0;
    cfg_we = 1'b1; cfg_id = id; cfg_sel = sel; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
    m_vld = 1'b1; m_id = id; m_sel = sel; m_mask = m;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r0;
    void'($urandom(32'd20250525));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_id = '0; cfg_sel = '0; cfg_mask = '0;
    iss_valid = 1'b0; iss_id = '0; iss_a = '0; iss_b = '0;
    #12;
    check("R4 reset idle", 1'b0, 1'b0, '0);
    @(negedge clk); rst_n = 1'b1;

    // R1: nothing resident, even id 0 traps
    issue_chk("R1 empty id0", 11'h000, 32'h1, 32'h2);
    issue_chk("R1 empty id7ff", 11'h7FF, 32'h5, 32'h6);

    // R4: idle
    @(negedge clk); iss_valid = 1'b0; #1;
    check("R4 idle", 1'b0, 1'b0, '0);

    // R5: write cycle still uses old (empty) configuration
    @(negedge clk);
    cfg_we = 1'b1; cfg_id = 11'h123; cfg_sel = 2'd0; cfg_mask = '0;
    iss_valid = 1'b1; iss_id = 11'h123; iss_a = 32'hF0F0_0001; iss_b = '0;
    #1;
    check("R5 write cycle old cfg", 1'b0, 1'b1, '0);
    @(negedge clk);
    cfg_we = 1'b0;
    m_vld = 1'b1; m_id = 11'h123; m_sel = 2'd0; m_mask = '0;
    #1;
    check("R5 next cycle new cfg", 1'b1, 1'b0, 32'd9);

    // R6 popcount corners
    issue_chk("R6 pop zero", 11'h123, 32'h0, 32'h0);
    issue_chk("R6 pop ones", 11'h123, 32'hFFFF_FFFF, 32'h0);
    // R3 mismatch
    issue_chk("R3 mismatch", 11'h124, 32'hFFFF_FFFF, 32'h1);

    // R7 bit reverse
    load_cfg(11'h2A5, 2'd1, '0);
    issue_chk("R7 rev lsb", 11'h2A5, 32'h0000_0001, 32'h0);
    issue_chk("R7 rev pattern", 11'h2A5, 32'h1234_5678, 32'h0);
    issue_chk("R3 stale id", 11'h123, 32'h1, 32'h0);

    // R8 masked merge
    load_cfg(11'h001, 2'd2, 32'hFFFF_0000);
    issue_chk("R8 merge halves", 11'h001, 32'hAAAA_AAAA, 32'h5555_5555);
    issue_chk("R8 merge other", 11'h001, 32'h0000_FFFF, 32'hFFFF_0000);

    // R9 saturating add
    load_cfg(11'h7FF, 2'd3, '0);
    issue_chk("R9 sat plain", 11'h7FF, 32'd5, 32'd7);
    issue_chk("R9 sat overflow", 11'h7FF, 32'hFFFF_FFFF, 32'h1);
    issue_chk("R9 sat exact max", 11'h7FF, 32'hFFFF_FFFE, 32'h1);

    // R10 stateless: repeat after unrelated traffic
    issue_chk("R10 first", 11'h7FF, 32'h8000_0000, 32'h7000_0000);
    r0 = res_data;
    issue_chk("R10 noise", 11'h3, 32'hDEAD_BEEF, 32'h1);
    issue_chk("R10 noise2", 11'h7FF, 32'h1, 32'h1);
    issue_chk("R10 repeat", 11'h7FF, 32'h8000_0000, 32'h7000_0000);
    n_chk++;
    if (res_data !== r0) begin
      n_err++;
      $display("FAIL R10: actual %h expected %h", res_data, r0);
    end

    // random mix, R2 R3 R5 R11
    for (int k = 0; k < 400; k++) begin
      bit           we  = ($urandom % 4) == 0;
      logic [10:0]  nid = 11'($urandom);
      logic [1:0]   ns  = 2'($urandom);
      logic [W-1:0] nm  = $urandom;
      logic [10:0]  id  = (($urandom % 3) != 0) ? m_id : 11'($urandom);
      logic [W-1:0] a   = (($urandom % 8) == 0) ? 32'hFFFF_FFF0 : $urandom;
      logic [W-1:0] b   = $urandom;
      bit           v   = ($urandom % 6) != 0;
      bit           h;
      @(negedge clk);
      cfg_we = we; cfg_id = nid; cfg_sel = ns; cfg_mask = nm;
      iss_valid = v; iss_id = id; iss_a = a; iss_b = b;
      #1;
      h = v && m_vld && (id == m_id);
      check(h ? "R2 random hit" : (v ? "R3 random miss" : "R4 random idle"),
            h, v && !h, h ? f_exp(m_sel, a, b, m_mask) : '0);
      if (we) begin
        m_vld = 1'b1; m_id = nid; m_sel = ns; m_mask = nm;
      end
    end

    @(negedge clk); cfg_we = 1'b0; iss_valid = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule